// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block moves one 8-bit companded voice sample per frame between a codec's internal sample registers and a pair of serial pins. It has one transmit pin with an output enable, so the pin can float, and one receive pin. A frame sync marks each frame. The sample sits in one of two channel slots, B1 or B2. The two slots are either back to back or separated by two idle bit periods.

The port runs on the bit clock. The frame sync is sampled on the rising edge. Transmit data is launched from rising-edge state, and receive data is sampled on the falling edge. Samples travel most significant bit first.

Static control inputs select several options:
- the frame timing mode;
- the active channel;
- the slot layout;
- a seven-bit mode, which leaves the last bit period of the slot unused;
- a digital loopback;
- register overrides for either direction;
- a global enable.

Software can write the receive data register and can read it back at any time.

Top module: `pcm_slot_port`

## Requirements
- R1: While `rst` is high and right after it falls, `tx_oe` and `dec_valid` are 0 and `rxreg_q` is 0.
- R2: Bit positions are counted from the rising clock edge at which `fsync` is sampled high. With `cfg_nodelay`=0 (delayed timing), position 0 is the bit period that starts one clock after that edge. With `cfg_nodelay`=1, position 0 is the bit period that starts at that edge. If `cfg_rev`=1 is also set, the two slots trade places: B2 takes the first slot and B1 the second.
- R3: The first slot covers positions 0 to 7. The second slot starts at position 8 when `cfg_gap`=0 and at position 10 when `cfg_gap`=1.
- R4: `cfg_chan`=0 selects B1 and `cfg_chan`=1 selects B2. During the 8 bit periods of the active slot, `tx_oe`=1 and `txd` carries the sample MSB first. Outside that slot, `tx_oe`=0.
- R5: `rxd` is sampled on falling edges in the active slot, MSB first. After the falling edge of the last slot bit, the byte appears on `dec_sample` and `rxreg_q`, and `dec_valid` is high for exactly one clock. `dec_valid` does not pulse at any other time.
- R6: With `cfg_en`=0, `tx_oe` stays 0, `dec_valid` stays 0 and `rxreg_q` is not changed by `rxd`.
- R7: With `cfg_b7`=1, `tx_oe` is 0 during the last (LSB) bit period of the slot, and the received LSB is stored as 0.
- R8: With `cfg_loop`=1, the received byte is still written to `rxreg_q` but `dec_valid` never pulses. TX sends the value `rxreg_q` held when the slot began.
- R9: With `cfg_rx_ovr`=1, `rxd` is ignored and `rxreg_q` is not overwritten by received data. Every frame, `dec_sample` presents `rxreg_q` with a `dec_valid` pulse.
- R10: With `cfg_tx_ovr`=1 and `cfg_loop`=0, TX sends `txreg_data` instead of `enc_sample`.
- R11: The transmit word is latched at the rising edge that begins the active slot. Changes on `enc_sample` later in that slot do not affect the bits sent.
- R12: A one-cycle pulse of `rxreg_we` loads `rxreg_wdata` into `rxreg_q` at the following falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, sampled on the rising edge |
| rxd | input | 1 | Serial receive data |
| cfg_gap | input | 1 | 1 inserts two idle bits between the slots |
| cfg_chan | input | 1 | Active channel: 0 = B1, 1 = B2 |
| cfg_en | input | 1 | Transfer enable |
| cfg_b7 | input | 1 | Seven-bit sample mode |
| cfg_loop | input | 1 | Digital loopback |
| cfg_rx_ovr | input | 1 | Receive path fed from the register |
| cfg_tx_ovr | input | 1 | Transmit fed from the TX register |
| cfg_nodelay | input | 1 | 0 = delayed timing, 1 = non-delayed |
| cfg_rev | input | 1 | In non-delayed timing, swap slot order |
| enc_sample | input | 8 | Sample from the encoder |
| txreg_data | input | 8 | TX override register value |
| rxreg_wdata | input | 8 | Write data for the RX register |
| rxreg_we | input | 1 | RX register write strobe |
| txd | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit output enable (0 = high impedance) |
| rxreg_q | output | 8 | RX data register contents |
| dec_sample | output | 8 | Sample handed to the decoder |
| dec_valid | output | 1 | One-clock strobe for `dec_sample` |

## Verification
The assertions check the following properties on every clock:
- transmit stays off in the bit period after a delayed-mode sync;
- no transmit burst runs longer than the slot, and none is longer than seven bits in seven-bit mode;
- the decode strobe lasts one clock and never appears while the port is disabled or in loopback;
- the RX register holds still under receive override unless it is written.

Only the bench's frames can show the rest:
- exact slot placement for each timing mode, layout and channel;
- the bit order on both pins;
- the moment the transmit word is latched;
- that the loopback echoes the previous frame's byte.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    localparam int SAMPLE_W   = 8;
    localparam int GAP_BITS   = 2;
    localparam int FRAME_LAST = 2 * SAMPLE_W + GAP_BITS - 1;
    localparam int POS_W      = $clog2(FRAME_LAST + 2);

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [POS_W-1:0]    pos_t;

    typedef enum logic [1:0] {
        TM_DELAYED  = 2'd0,
        TM_NORMAL   = 2'd1,
        TM_REVERSED = 2'd2
    } timing_e;

    typedef struct packed {
        logic    gapped;
        logic    chan_b2;
        logic    enable;
        logic    seven_bit;
        logic    loopback;
        logic    rx_override;
        logic    tx_override;
        timing_e timing;
    } port_cfg_t;

    typedef struct packed {
        logic in_slot;
        logic last_bit;
        logic lsb_masked;
        pos_t bit_idx;
        logic slot_begin_next;
    } slot_info_t;

    function automatic timing_e decode_timing(logic nodelay, logic rev);
        if (!nodelay) return TM_DELAYED;
        return rev ? TM_REVERSED : TM_NORMAL;
    endfunction

    function automatic pos_t slot_start(logic second, logic gapped);
        if (!second) return '0;
        return gapped ? pos_t'(SAMPLE_W + GAP_BITS) : pos_t'(SAMPLE_W);
    endfunction

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
    import pcm_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fsync,
    input  port_cfg_t  cfg,
    output slot_info_t slot
);

    pos_t pos_q, pos_n;
    logic act_q, act_n;
    logic pend_q, pend_n;

    always_comb begin
        pos_n  = pos_q;
        act_n  = act_q;
        pend_n = 1'b0;
        if (fsync) begin
            pos_n = '0;
            if (cfg.timing == TM_DELAYED) begin
                act_n  = 1'b0;
                pend_n = 1'b1;
            end else begin
                act_n = 1'b1;
            end
        end else if (pend_q) begin
            act_n = 1'b1;
            pos_n = '0;
        end else if (act_q) begin
            if (pos_q == pos_t'(FRAME_LAST)) act_n = 1'b0;
            else                             pos_n = pos_q + pos_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            act_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            pos_q  <= pos_n;
            act_q  <= act_n;
            pend_q <= pend_n;
        end
    end

    logic second;
    pos_t start, stop, rel;

    always_comb begin
        second = cfg.chan_b2 ^ (cfg.timing == TM_REVERSED);
        start  = slot_start(second, cfg.gapped);
        stop   = start + pos_t'(SAMPLE_W);
        rel    = pos_q - start;
        slot.in_slot         = act_q && (pos_q >= start) && (pos_q < stop);
        slot.bit_idx         = rel;
        slot.last_bit        = slot.in_slot && (rel == pos_t'(SAMPLE_W - 1));
        slot.lsb_masked      = slot.last_bit && cfg.seven_bit;
        slot.slot_begin_next = act_n && (pos_n == start);
    end

endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
    import pcm_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  port_cfg_t  cfg,
    input  slot_info_t slot,
    input  sample_t    enc_sample,
    input  sample_t    txreg_data,
    input  sample_t    rxreg_q,
    output logic       txd,
    output logic       tx_oe
);

    sample_t word_q, pick, shifted;
    logic    drive;

    always_comb begin
        if (cfg.loopback)         pick = rxreg_q;
        else if (cfg.tx_override) pick = txreg_data;
        else                      pick = enc_sample;
    end

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else if (slot.slot_begin_next && cfg.enable)
            word_q <= pick;
    end

    always_comb begin
        drive   = cfg.enable && slot.in_slot && !slot.lsb_masked;
        shifted = word_q << slot.bit_idx;
        tx_oe   = drive;
        txd     = drive ? shifted[SAMPLE_W-1] : 1'b0;
    end

endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
    import pcm_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  port_cfg_t  cfg,
    input  slot_info_t slot,
    input  logic       rxd,
    input  sample_t    rxreg_wdata,
    input  logic       rxreg_we,
    output sample_t    rxreg_q,
    output sample_t    dec_sample,
    output logic       dec_valid
);

    logic [SAMPLE_W-2:0] sh_q;
    sample_t             full;

    always_comb full = {sh_q, (cfg.seven_bit ? 1'b0 : rxd)};

    always_ff @(negedge clk) begin
        if (rst) begin
            sh_q       <= '0;
            rxreg_q    <= '0;
            dec_sample <= '0;
            dec_valid  <= 1'b0;
        end else begin
            dec_valid <= 1'b0;
            if (rxreg_we) rxreg_q <= rxreg_wdata;
            if (cfg.enable && slot.in_slot) begin
                if (!slot.last_bit) begin
                    sh_q <= {sh_q[SAMPLE_W-3:0], rxd};
                end else begin
                    if (!cfg.rx_override) rxreg_q <= full;
                    if (!cfg.loopback) begin
                        dec_valid  <= 1'b1;
                        dec_sample <= cfg.rx_override ? rxreg_q : full;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fsync,
    input  logic       rxd,
    input  logic       cfg_gap,
    input  logic       cfg_chan,
    input  logic       cfg_en,
    input  logic       cfg_b7,
    input  logic       cfg_loop,
    input  logic       cfg_rx_ovr,
    input  logic       cfg_tx_ovr,
    input  logic       cfg_nodelay,
    input  logic       cfg_rev,
    input  logic [7:0] enc_sample,
    input  logic [7:0] txreg_data,
    input  logic [7:0] rxreg_wdata,
    input  logic       rxreg_we,
    output logic       txd,
    output logic       tx_oe,
    output logic [7:0] rxreg_q,
    output logic [7:0] dec_sample,
    output logic       dec_valid
);

    port_cfg_t  cfg;
    slot_info_t slot;

    always_comb begin
        cfg.gapped      = cfg_gap;
        cfg.chan_b2     = cfg_chan;
        cfg.enable      = cfg_en;
        cfg.seven_bit   = cfg_b7;
        cfg.loopback    = cfg_loop;
        cfg.rx_override = cfg_rx_ovr;
        cfg.tx_override = cfg_tx_ovr;
        cfg.timing      = decode_timing(cfg_nodelay, cfg_rev);
    end

    pcm_frame_timer u_timer (
        .clk   (clk),
        .rst   (rst),
        .fsync (fsync),
        .cfg   (cfg),
        .slot  (slot)
    );

    pcm_tx_path u_tx (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .slot       (slot),
        .enc_sample (enc_sample),
        .txreg_data (txreg_data),
        .rxreg_q    (rxreg_q),
        .txd        (txd),
        .tx_oe      (tx_oe)
    );

    pcm_rx_path u_rx (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .slot        (slot),
        .rxd         (rxd),
        .rxreg_wdata (rxreg_wdata),
        .rxreg_we    (rxreg_we),
        .rxreg_q     (rxreg_q),
        .dec_sample  (dec_sample),
        .dec_valid   (dec_valid)
    );

endmodule

module pcm_slot_port_chk
    import pcm_port_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       fsync,
    input logic       cfg_en,
    input logic       cfg_b7,
    input logic       cfg_loop,
    input logic       cfg_rx_ovr,
    input logic       cfg_nodelay,
    input logic       rxreg_we,
    input logic       tx_oe,
    input logic       dec_valid,
    input logic [7:0] rxreg_q
);

    pos_t run;

    always_ff @(posedge clk) begin
        if (rst)        run <= '0;
        else if (tx_oe) run <= run + pos_t'(1);
        else            run <= '0;
    end

    // R2
    delayed_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(fsync) && !cfg_nodelay) |-> !tx_oe);

    // R7
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        run <= (cfg_b7 ? pos_t'(SAMPLE_W - 1) : pos_t'(SAMPLE_W)));

    // R5
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);

    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |-> (!tx_oe && !dec_valid));

    // R8
    loop_no_decode_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_loop |-> !dec_valid);

    // R9
    override_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rx_ovr && !rxreg_we) |-> $stable(rxreg_q));

endmodule

bind pcm_slot_port pcm_slot_port_chk u_chk (.*);

// File: tb/pcm_slot_port_test.sv
module pcm_slot_port_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fsync = 1'b0, rxd = 1'b0;
    logic       cfg_gap = 0, cfg_chan = 0, cfg_en = 0, cfg_b7 = 0, cfg_loop = 0;
    logic       cfg_rx_ovr = 0, cfg_tx_ovr = 0, cfg_nodelay = 0, cfg_rev = 0;
    logic [7:0] enc_sample = '0, txreg_data = '0, rxreg_wdata = '0;
    logic       rxreg_we = 1'b0;
    logic       txd, tx_oe, dec_valid;
    logic [7:0] rxreg_q, dec_sample;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mdl_rx = '0;

    always #4 clk = ~clk;

    pcm_slot_port uut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic set_cfg(input bit en, input bit chan, input bit gap, input bit nd,
                           input bit rev, input bit b7, input bit lp, input bit ro,
                           input bit to);
        @(posedge clk); #1;
        cfg_en = en; cfg_chan = chan; cfg_gap = gap; cfg_nodelay = nd; cfg_rev = rev;
        cfg_b7 = b7; cfg_loop = lp; cfg_rx_ovr = ro; cfg_tx_ovr = to;
    endtask

    task automatic wr_rx(input logic [7:0] d);
        @(posedge clk); #1;
        rxreg_we = 1'b1; rxreg_wdata = d;
        @(posedge clk); #1;
        rxreg_we = 1'b0;
        #1;
        check(rxreg_q == d, "R12", "rx register write", rxreg_q, d);
        mdl_rx = d;
    endtask

    task automatic do_frame(input string tag, input logic [7:0] rxb,
                            input logic [7:0] enc, input logic [7:0] treg,
                            input bit mutate);
        int off, st, last_c;
        logic [7:0] word, full, exp_dec;
        bit second;
        off    = cfg_nodelay ? 1 : 2;
        second = cfg_chan ^ (cfg_nodelay & cfg_rev);
        st     = second ? (cfg_gap ? 10 : 8) : 0;
        last_c = off + st + 7;
        word   = cfg_loop ? mdl_rx : (cfg_tx_ovr ? treg : enc);
        full   = cfg_b7 ? {rxb[7:1], 1'b0} : rxb;
        exp_dec = cfg_rx_ovr ? mdl_rx : full;
        enc_sample = enc; txreg_data = treg;
        for (int c = 0; c < 24; c++) begin
            int f, bi;
            bit in, exp_oe, exp_v;
            @(posedge clk); #1;
            fsync = (c == 0);
            f  = c - off;
            bi = f - st;
            in = (f >= st) && (f < st + 8);
            rxd = in ? rxb[7-bi] : 1'($urandom % 2);
            if (mutate && in && bi == 3) enc_sample = ~enc;
            #1;
            exp_oe = cfg_en && in && !(cfg_b7 && bi == 7);
            check(tx_oe == exp_oe, tag, $sformatf("tx_oe pos %0d", f), tx_oe, exp_oe);
            if (exp_oe && tx_oe)
                check(txd == word[7-bi], tag, $sformatf("txd bit %0d", bi), txd, word[7-bi]);
            exp_v = cfg_en && !cfg_loop && (c == last_c + 1);
            check(dec_valid == exp_v, tag, "dec_valid", dec_valid, exp_v);
            if (exp_v && dec_valid)
                check(dec_sample == exp_dec, tag, "dec_sample", dec_sample, exp_dec);
        end
        if (cfg_en && !cfg_rx_ovr) mdl_rx = full;
        check(rxreg_q == mdl_rx, tag, "rx register", rxreg_q, mdl_rx);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL R4 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1 reset state
        check(tx_oe == 0, "R1", "tx_oe after reset", tx_oe, 0);
        check(dec_valid == 0, "R1", "dec_valid after reset", dec_valid, 0);
        check(rxreg_q == 0, "R1", "rxreg_q after reset", rxreg_q, 0);

        // R2 R4 delayed timing, B1 and B2 back to back
        set_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0);
        do_frame("R4", 8'hA5, 8'h3C, 8'h00, 0);
        set_cfg(1, 1, 0, 0, 0, 0, 0, 0, 0);
        do_frame("R2", 8'h5A, 8'hC3, 8'h00, 0);
        // R3 gapped layout
        set_cfg(1, 1, 1, 0, 0, 0, 0, 0, 0);
        do_frame("R3", 8'h81, 8'h7E, 8'h00, 0);
        // R2 non-delayed normal and reversed
        set_cfg(1, 0, 0, 1, 0, 0, 0, 0, 0);
        do_frame("R2", 8'h0F, 8'hF0, 8'h00, 0);
        set_cfg(1, 0, 1, 1, 1, 0, 0, 0, 0);
        do_frame("R2", 8'hE7, 8'h18, 8'h00, 0);
        set_cfg(1, 1, 1, 1, 1, 0, 0, 0, 0);
        do_frame("R3", 8'h66, 8'h99, 8'h00, 0);
        // R5 all-ones and all-zeros samples
        set_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0);
        do_frame("R5", 8'hFF, 8'h00, 8'h00, 0);
        do_frame("R5", 8'h00, 8'hFF, 8'h00, 0);
        // R7 seven-bit mode, odd sample so the LSB must be dropped
        set_cfg(1, 1, 1, 0, 0, 1, 0, 0, 0);
        do_frame("R7", 8'hB7, 8'hFF, 8'h00, 0);
        // R8 loopback over two frames
        set_cfg(1, 0, 0, 0, 0, 0, 1, 0, 0);
        do_frame("R8", 8'h4D, 8'h11, 8'h22, 0);
        do_frame("R8", 8'hD2, 8'h11, 8'h22, 0);
        // R9 receive override with a software write
        set_cfg(1, 0, 1, 0, 0, 0, 0, 1, 0);
        wr_rx(8'h6B);
        do_frame("R9", 8'h94, 8'h12, 8'h00, 0);
        // R10 transmit override
        set_cfg(1, 1, 0, 1, 0, 0, 0, 0, 1);
        do_frame("R10", 8'h2E, 8'h55, 8'hC9, 0);
        // R11 encoder changes during the slot
        set_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0);
        do_frame("R11", 8'h71, 8'hA3, 8'h00, 1);
        // R6 disabled: nothing driven, register untouched
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_frame("R6", 8'hEE, 8'h77, 8'h00, 0);
        set_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0);
        wr_rx(8'h3A);

        for (int k = 0; k < 200; k++) begin
            set_cfg(($urandom % 8) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), ($urandom % 4) == 0,
                    ($urandom % 4) == 0, 1'($urandom));
            if (cfg_rx_ovr && ($urandom % 2)) wr_rx(8'($urandom));
            do_frame("R4", 8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
        end

        summary();
        $finish;
    end

endmodule